// File: doc/BRIEF.md
# Packed Stack-Machine Instruction Sequencer

This block is the front end of a 32-bit stack processor. Code and literal data share one memory that has a single synchronous read port. The sequencer fetches program words and uses the upper two bits of each word to tell its format. A packed word carries five 6-bit short opcodes, which the block hands out one per clock on an issue strobe. A long word carries one control-flow operation with a 24-bit absolute word address.

A literal opcode is issued like any other short opcode. In the same clock the sequencer reads the word that follows the program stream, and it presents that full 32-bit word on a push strobe one clock later. Several literals in one packed word consume the following words in turn, and fetching resumes after the last one. A jump, call, conditional jump or return discards whatever slots remain and refetches from the new pointer. A call reports its return address so that an external return stack can save it. A return reloads the pointer from an external return-address input.

The data-stack ALU and the return-stack storage live outside this block. The block only emits the strobes that drive them.

Top module: `packed_issue_seq`

## Requirements
- R1: A synchronous reset sets the instruction pointer to 0 and clears the slot position. In the first clock after reset the block requests a read at address 0 and asserts none of opValid, litPush, callPush or retPop.
- R2: A word whose bits [31:30] are 00 is packed. Slot k occupies bits [6k+5:6k], with slot 0 in the low bits. Non-zero slots are issued in order 0 to 4 on opCode, one per clock, with opValid high.
- R3: Opcode 1 is a literal. It is issued on opCode like any other short opcode, and one clock later litPush is high and litValue carries the next unread word that follows the packed word. Literals in the same word take successive words in order, and the next instruction fetch is at the word after the last literal.
- R4: A slot that holds opcode 0 is not issued. The remaining slots of that word are dropped, and the next instruction word is fetched without a further issue cycle.
- R5: A word whose bits [31:30] are 01 is long. Bits [29:24] select the operation and bits [23:0] hold the target. Operation 0 is a jump: no short opcode is issued from the word, and the next fetch is at the target.
- R6: Operation 1 is a call. It asserts callPush for one clock with callRetAddr set to the address of the word after the call, and the next fetch is at the target.
- R7: Operation 2 is a conditional jump. It goes to the target when takenIn is high in its decode cycle, and to the next word otherwise.
- R8: Operation 3 is a return. It asserts retPop for one clock, and the next fetch is at the value of retAddrIn sampled in that cycle.
- R9: A long word with any other operation code, or a word tagged 10 or 11, has no effect, and sequencing continues at the next word.
- R10: Read data is expected one clock after memRd. opValid and litPush are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memRd | output | 1 | Read request to the shared memory |
| memAddr | output | 24 | Word address of the read request |
| memData | input | 32 | Read data, valid one clock after memRd |
| takenIn | input | 1 | Condition for a conditional jump |
| retAddrIn | input | 24 | Top of the external return stack |
| opValid | output | 1 | Short opcode issue strobe |
| opCode | output | 6 | Issued short opcode |
| litPush | output | 1 | Literal push strobe |
| litValue | output | 32 | Literal word to push |
| callPush | output | 1 | Call strobe for the return stack |
| callRetAddr | output | 24 | Return address saved by a call |
| retPop | output | 1 | Return strobe for the return stack |

## Verification
The issue of a literal opcode and the memory read of its literal word fall in the same clock, so a mistake there moves the literal stream against the program stream. The bench provokes this with words full of literals, with a literal in the last slot, and with literal words whose own tag bits look like control flow. It then judges every issue, push, call and return strobe against an instruction-level model that walks the same memory image. It also checks cycle by cycle that a push follows each literal issue exactly one clock later and never coincides with an issue.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [1:0] {
    S_FETCH,
    S_LOAD,
    S_ISSUE,
    S_LITGET
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fetchBump;
    logic loadWord;
    logic slotStep;
    logic ipToTarget;
    logic ipToRet;
  } dpCtl_t;

  localparam int OP_NOP    = 0;
  localparam int OP_LIT    = 1;
  localparam int TAG_PACK  = 0;
  localparam int TAG_LONG  = 1;
  localparam int KIND_JMP  = 0;
  localparam int KIND_CALL = 1;
  localparam int KIND_CJMP = 2;
  localparam int KIND_RET  = 3;

endpackage

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issue_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int TAG_W  = 2,
  parameter int KIND_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  wordTag,
  input  logic [KIND_W-1:0] longKind,
  input  logic [SLOT_W-1:0] curOp,
  input  logic              lastSlot,
  input  logic              takenIn,
  output logic              memRd,
  output logic              opValid,
  output logic              litPush,
  output logic              callPush,
  output logic              retPop,
  output dpCtl_t            dpCtl
);

  seqState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    dpCtl     = '0;
    memRd     = 1'b0;
    opValid   = 1'b0;
    litPush   = 1'b0;
    callPush  = 1'b0;
    retPop    = 1'b0;
    unique case (state)
      S_FETCH: begin
        memRd           = 1'b1;
        dpCtl.fetchBump = 1'b1;
        stateNext       = S_LOAD;
      end
      S_LOAD: begin
        dpCtl.loadWord = 1'b1;
        stateNext      = S_ISSUE;
      end
      S_ISSUE: begin
        if (wordTag == TAG_W'(TAG_LONG)) begin
          stateNext = S_FETCH;
          if (longKind == KIND_W'(KIND_JMP)) begin
            dpCtl.ipToTarget = 1'b1;
          end else if (longKind == KIND_W'(KIND_CALL)) begin
            callPush         = 1'b1;
            dpCtl.ipToTarget = 1'b1;
          end else if (longKind == KIND_W'(KIND_CJMP)) begin
            dpCtl.ipToTarget = takenIn;
          end else if (longKind == KIND_W'(KIND_RET)) begin
            retPop        = 1'b1;
            dpCtl.ipToRet = 1'b1;
          end
        end else if (wordTag == TAG_W'(TAG_PACK)) begin
          if (curOp == SLOT_W'(OP_NOP)) begin
            stateNext = S_FETCH;
          end else begin
            opValid = 1'b1;
            if (curOp == SLOT_W'(OP_LIT)) begin
              // literal word read overlaps the issue cycle
              memRd           = 1'b1;
              dpCtl.fetchBump = 1'b1;
              stateNext       = S_LITGET;
            end else if (lastSlot) begin
              stateNext = S_FETCH;
            end else begin
              dpCtl.slotStep = 1'b1;
            end
          end
        end else begin
          stateNext = S_FETCH;
        end
      end
      S_LITGET: begin
        litPush = 1'b1;
        if (lastSlot) begin
          stateNext = S_FETCH;
        end else begin
          dpCtl.slotStep = 1'b1;
          stateNext      = S_ISSUE;
        end
      end
      default: stateNext = S_FETCH;
    endcase
  end

  // R4: a filler slot sends the sequencer straight back to fetch
  p_nop_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_ISSUE && wordTag == TAG_W'(TAG_PACK) && curOp == SLOT_W'(OP_NOP))
      |=> (state == S_FETCH));

  // R3: a literal fetch always lands in the push state
  p_lit_state_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_ISSUE && opValid && curOp == SLOT_W'(OP_LIT)) |=> (state == S_LITGET));

endmodule

// File: rtl/issue_dpath.sv
module issue_dpath
  import issue_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 6,
  parameter int SLOTS  = 5,
  parameter int TAG_W  = 2,
  parameter int KIND_W = 6,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dpCtl,
  input  logic [WORD_W-1:0] memData,
  input  logic [ADDR_W-1:0] retAddrIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [TAG_W-1:0]  wordTag,
  output logic [KIND_W-1:0] longKind,
  output logic [SLOT_W-1:0] curOp,
  output logic              lastSlot,
  output logic [WORD_W-1:0] litValue,
  output logic [ADDR_W-1:0] callRetAddr
);

  localparam int SLOT_IDX_W = $clog2(SLOTS);
  localparam int KIND_LSB   = WORD_W - TAG_W - KIND_W;

  logic [ADDR_W-1:0]     ipReg;
  logic [WORD_W-1:0]     wordReg;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic [SLOT_W-1:0]     slotArr [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ipReg   <= '0;
      wordReg <= '0;
      slotIdx <= '0;
    end else begin
      if (dpCtl.ipToTarget)     ipReg <= wordReg[ADDR_W-1:0];
      else if (dpCtl.ipToRet)   ipReg <= retAddrIn;
      else if (dpCtl.fetchBump) ipReg <= ipReg + ADDR_W'(1);
      if (dpCtl.loadWord) begin
        wordReg <= memData;
        slotIdx <= '0;
      end else if (dpCtl.slotStep) begin
        slotIdx <= slotIdx + SLOT_IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slotArr[g] = wordReg[g*SLOT_W +: SLOT_W];
  end

  always_comb begin
    curOp = '0;
    for (int k = 0; k < SLOTS; k++)
      if (slotIdx == SLOT_IDX_W'(k)) curOp = slotArr[k];
  end

  assign lastSlot    = (slotIdx == SLOT_IDX_W'(SLOTS - 1));
  assign wordTag     = wordReg[WORD_W-1 -: TAG_W];
  assign longKind    = wordReg[KIND_LSB +: KIND_W];
  assign memAddr     = ipReg;
  assign litValue    = memData;
  assign callRetAddr = ipReg;

  // R2: the slot position never leaves the packed word
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (rst)
    slotIdx <= SLOT_IDX_W'(SLOTS - 1));

  // R5: a redirect replaces the pointer with the word's target field
  p_target_load_r5: assert property (@(posedge clk) disable iff (rst)
    dpCtl.ipToTarget |=> (ipReg == $past(wordReg[ADDR_W-1:0])));

endmodule

// File: rtl/packed_issue_seq.sv
module packed_issue_seq
  import issue_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 6,
  parameter int SLOTS  = 5,
  parameter int TAG_W  = 2,
  parameter int KIND_W = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  output logic                               memRd,
  output logic [WORD_W-TAG_W-KIND_W-1:0]     memAddr,
  input  logic [WORD_W-1:0]                  memData,
  input  logic                               takenIn,
  input  logic [WORD_W-TAG_W-KIND_W-1:0]     retAddrIn,
  output logic                               opValid,
  output logic [SLOT_W-1:0]                  opCode,
  output logic                               litPush,
  output logic [WORD_W-1:0]                  litValue,
  output logic                               callPush,
  output logic [WORD_W-TAG_W-KIND_W-1:0]     callRetAddr,
  output logic                               retPop
);

  localparam int ADDR_W = WORD_W - TAG_W - KIND_W;

  dpCtl_t            dpCtl;
  logic [TAG_W-1:0]  wordTag;
  logic [KIND_W-1:0] longKind;
  logic              lastSlot;

  issue_ctrl #(.SLOT_W(SLOT_W), .TAG_W(TAG_W), .KIND_W(KIND_W)) u_ctrl (
    .clk(clk), .rst(rst), .wordTag(wordTag), .longKind(longKind),
    .curOp(opCode), .lastSlot(lastSlot), .takenIn(takenIn),
    .memRd(memRd), .opValid(opValid), .litPush(litPush),
    .callPush(callPush), .retPop(retPop), .dpCtl(dpCtl)
  );

  issue_dpath #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .TAG_W(TAG_W),
                .KIND_W(KIND_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .memData(memData), .retAddrIn(retAddrIn),
    .memAddr(memAddr), .wordTag(wordTag), .longKind(longKind), .curOp(opCode),
    .lastSlot(lastSlot), .litValue(litValue), .callRetAddr(callRetAddr)
  );

  // R1: first clock out of reset reads address 0
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (memRd && memAddr == '0 && !opValid && !litPush));

  // R3: a literal issue is followed by its push one clock later
  p_lit_next_r3: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == SLOT_W'(OP_LIT)) |=> litPush);

  // R10: issue and push strobes never coincide
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !(opValid && litPush));

  // R8: a return redirects the next read to the sampled return address
  p_ret_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    retPop |=> (memRd && memAddr == $past(retAddrIn)));

  // R6: a call is followed by the fetch at its target
  p_call_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    callPush |=> memRd);

endmodule

// File: tb/test_packed_issue_seq.sv
module test_packed_issue_seq;

  localparam int PERIOD   = 10;
  localparam int MEMN     = 64;
  localparam int MAXEV    = 4000;
  localparam int EV_OP    = 0;
  localparam int EV_LIT   = 1;
  localparam int EV_CALL  = 2;
  localparam int EV_RET   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memRd;
  logic [23:0] memAddr;
  logic [31:0] memData = '0;
  logic        takenIn = 1'b0;
  logic [23:0] retAddrIn = '0;
  logic        opValid;
  logic [5:0]  opCode;
  logic        litPush;
  logic [31:0] litValue;
  logic        callPush;
  logic [23:0] callRetAddr;
  logic        retPop;

  logic [31:0] mem [MEMN];
  int          evKind [MAXEV];
  logic [31:0] evVal  [MAXEV];
  int          nModel;
  int          evIdx;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  packed_issue_seq i_packed_issue_seq (
    .clk(clk), .rst(rst), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .takenIn(takenIn), .retAddrIn(retAddrIn), .opValid(opValid), .opCode(opCode),
    .litPush(litPush), .litValue(litValue), .callPush(callPush),
    .callRetAddr(callRetAddr), .retPop(retPop)
  );

  // synchronous memory: data one clock after the request (R10)
  always @(posedge clk) if (memRd) memData <= mem[memAddr[5:0]];

  function automatic logic [31:0] pk(int s0, int s1, int s2, int s3, int s4);
    return {2'b00, 6'(s4), 6'(s3), 6'(s2), 6'(s1), 6'(s0)};
  endfunction

  function automatic logic [31:0] lg(int kind, int tgt);
    return {2'b01, 6'(kind), 24'(tgt)};
  endfunction

  function automatic int randSlot();
    int r = int'($urandom % 12);
    if (r == 0) return 0;
    if (r < 4)  return 1;
    return 2 + int'($urandom % 62);
  endfunction

  task automatic addEv(int k, logic [31:0] v);
    if (nModel < MAXEV) begin
      evKind[nModel] = k;
      evVal[nModel]  = v;
      nModel++;
    end
  endtask

  // instruction-level reference model built from the requirements
  task automatic buildModel(bit tk, logic [23:0] ra);
    logic [23:0] ip = '0;
    logic [31:0] w;
    int steps = 0;
    nModel = 0;
    while (nModel < MAXEV - 8 && steps < 4000) begin
      steps++;
      w  = mem[ip[5:0]];
      ip = ip + 24'd1;
      if (w[31:30] == 2'b01) begin
        case (int'(w[29:24]))
          0: ip = w[23:0];                                   // R5
          1: begin addEv(EV_CALL, {8'h0, ip}); ip = w[23:0]; end // R6
          2: if (tk) ip = w[23:0];                           // R7
          3: begin addEv(EV_RET, '0); ip = ra; end           // R8
          default: ;                                         // R9
        endcase
      end else if (w[31:30] == 2'b00) begin
        bit stop = 1'b0;
        for (int s = 0; s < 5; s++) begin
          if (!stop) begin
            logic [5:0] op = w[6*s +: 6];
            if (op == 6'd0) stop = 1'b1;                     // R4
            else begin
              addEv(EV_OP, {26'h0, op});                     // R2
              if (op == 6'd1) begin                          // R3
                addEv(EV_LIT, mem[ip[5:0]]);
                ip = ip + 24'd1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic compareEv(int k, logic [31:0] v, string req);
    nChecks++;
    if (evIdx >= nModel || evKind[evIdx] != k || evVal[evIdx] != v) begin
      nFails++;
      $display("FAIL %s event %0d: actual kind %0d value %h, expected kind %0d value %h",
               req, evIdx, k, v,
               (evIdx < nModel) ? evKind[evIdx] : -1,
               (evIdx < nModel) ? evVal[evIdx] : 32'hx);
    end
    evIdx++;
  endtask

  task automatic runProgram(bit tk, logic [23:0] ra, int cycles);
    bit prevLit = 1'b0;
    buildModel(tk, ra);
    evIdx = 0;
    @(negedge clk);
    takenIn   = tk;
    retAddrIn = ra;
    rst       = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen in the first clock after release
    nChecks++;
    if (!(memRd === 1'b1 && memAddr === 24'd0 && opValid === 1'b0 && litPush === 1'b0 &&
          callPush === 1'b0 && retPop === 1'b0)) begin
      nFails++;
      $display("FAIL R1 reset: actual memRd=%b addr=%h opValid=%b litPush=%b, expected 1 000000 0 0",
               memRd, memAddr, opValid, litPush);
    end
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (prevLit) begin
        // R10 and R3: push exactly one clock after the literal issue
        nChecks++;
        if (litPush !== 1'b1) begin
          nFails++;
          $display("FAIL R10 literal push timing: actual litPush=%b, expected 1", litPush);
        end
      end
      if (opValid && litPush) begin
        nChecks++;
        nFails++;
        $display("FAIL R10 strobe overlap: actual opValid=1 litPush=1, expected at most one");
      end
      if (opValid)  compareEv(EV_OP, {26'h0, opCode}, "R2");
      if (litPush)  compareEv(EV_LIT, litValue, "R3");
      if (callPush) compareEv(EV_CALL, {8'h0, callRetAddr}, "R6");
      if (retPop)   compareEv(EV_RET, '0, "R8");
      prevLit = opValid && (opCode == 6'd1);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'd4242));
    // directed image: literals, filler, call, return, conditional, skipped words
    for (int i = 0; i < MEMN; i++) mem[i] = '0;
    mem[0]  = pk(5, 1, 1, 7, 0);       // R3 two literals, R4 filler ends the word
    mem[1]  = 32'hDEAD_BEEF;           // literal data with tag 11
    mem[2]  = lg(0, 40);               // literal data that looks like a jump
    mem[3]  = lg(1, 10);               // R6 call
    mem[4]  = lg(2, 20);               // R7 conditional jump
    mem[5]  = lg(0, 30);               // R5 jump (fall-through path)
    mem[10] = pk(9, 10, 11, 12, 1);    // R3 literal in the last slot
    mem[11] = 32'h1234_5678;
    mem[12] = lg(3, 0);                // R8 return
    mem[20] = pk(33, 34, 35, 36, 37);  // R2 full word
    mem[21] = 32'h8000_0000;           // R9 tag 10 skipped
    mem[22] = lg(9, 50);               // R9 unknown operation skipped
    mem[23] = pk(44, 1, 0, 45, 46);    // R4 filler after a literal
    mem[24] = 32'h0BAD_F00D;
    mem[25] = lg(0, 25);
    mem[30] = pk(2, 0, 8, 8, 8);
    mem[31] = lg(0, 31);
    runProgram(1'b1, 24'd4, 300);      // R7 taken
    runProgram(1'b0, 24'd4, 300);      // R7 not taken
    // constrained random images
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < MEMN; i++) begin
        int t = int'($urandom % 20);
        if (t < 14)      mem[i] = pk(randSlot(), randSlot(), randSlot(), randSlot(), randSlot());
        else if (t < 19) mem[i] = lg(int'($urandom % 5), int'($urandom % MEMN));
        else             mem[i] = {2'b1 + 2'($urandom % 2), 30'($urandom)};
      end
      runProgram(1'($urandom % 2), 24'($urandom % MEMN), 1500);
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule